// File: doc/BRIEF.md
# Debounced 4x4 Key Matrix Scanner

This block watches a 4-by-4 key matrix through four column drive outputs and four row sense inputs. While it waits, every column that is not masked is driven high, so any pressed key pulls its row high. When it detects a press, it drives the active-low key interrupt. It then either scans at once (automatic mode) or waits for a start command from the host (host mode). The scan strobes one column at a time. It keeps repeating full passes over the matrix until the whole 16-bit snapshot has stayed the same for a programmable debounce period.

When a scan completes, the snapshot goes to two read-only words. The pending word shows every key found. The status word clears the keys that the key mask hides. A column mask removes whole columns from both detection and scanning. The interrupt returns high when the scan finishes. It cannot fall again until the host reads one of the two result words. The host reaches all of this through a simple write/read strobe register port.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, keyirq_n is 1, col_drv is 0, and every register reads 0. The mode field is 00 (off), so no press is detected while the mode is off or 11.
- R2: In modes 10 and 01, while not scanning, col_drv drives 1 on every column whose column-mask bit is 0. A row input reading 1 counts as a press.
- R3: A scan drives at most one column at a time and samples the rows after the column has settled. The key in row r and column c is reported in bit r*4+c.
- R4: A scan finishes only after the full snapshot has stayed unchanged for the debounce period. The period is set by config bits [4:2]: codes 0 to 7 select 2, 10, 20, 50, 60, 80, 100 and 120 ms, where 1 ms is TICKS_PER_MS ticks of CLKS_PER_TICK clocks.
- R5: On completion, address 3 (pending) holds the full snapshot. Address 4 (status) holds the snapshot with every bit cleared whose key-mask bit (address 1) is 1.
- R6: Column-mask bit c (address 2, bits [3:0]) set to 1 means column c is never driven, its keys never raise the interrupt, and its bits read 0 in both result words.
- R7: keyirq_n falls on a detected press and rises when the scan completes (or when the mode is set to off). It does not fall again until a read of address 3 or 4.
- R8: Mode 10 (config bits [1:0]) starts the debounce scan automatically on a press.
- R9: In mode 01, a press only lowers keyirq_n and the columns stay all driven. Writing config with bit 8 set starts the scan.
- R10: Writes to addresses 3 and 4 have no effect.
- R11: Address 0 holds config bits [4:0] and reads back bits [4:0]. Bit 8 is a write-only start strobe and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (re-arms interrupt on addresses 3 and 4) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| row_in | input | 4 | Row sense inputs, 1 = active |
| col_drv | output | 4 | Column drive outputs, 1 = driven |
| keyirq_n | output | 1 | Active-low key interrupt |

## Verification
The bench builds the block with CLKS_PER_TICK=2, TICKS_PER_MS=3 and SYNC_STAGES=2. With these values code 0 lasts 12 clocks and code 1 lasts 60 clocks, so a bench run can measure exact debounce windows, including a window restarted by mid-scan bounce. The small periods leave room for dozens of random key, key-mask and column-mask patterns in both modes, checked against a behavioural model of the matrix.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int KEYS = ROWS * COLS;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_HOST = 2'b01,
        MODE_AUTO = 2'b10,
        MODE_RSVD = 2'b11
    } kp_mode_e;

    typedef enum logic [2:0] {
        ST_OFF, ST_DETECT, ST_HOLD, ST_COL, ST_EVAL
    } kp_state_e;

    typedef struct packed {
        logic [2:0] dbc;
        kp_mode_e   mode;
    } kp_cfg_t;

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_KMASK = 3'd1;
    localparam logic [2:0] A_CMASK = 3'd2;
    localparam logic [2:0] A_PEND  = 3'd3;
    localparam logic [2:0] A_STAT  = 3'd4;

    function automatic int unsigned dbc_ms(input logic [2:0] code);
        case (code)
            3'd0:    return 2;
            3'd1:    return 10;
            3'd2:    return 20;
            3'd3:    return 50;
            3'd4:    return 60;
            3'd5:    return 80;
            3'd6:    return 100;
            default: return 120;
        endcase
    endfunction

    function automatic logic [KEYS-1:0] col_bits(input logic [COLS-1:0] cm);
        logic [KEYS-1:0] b;
        b = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                b[r*COLS + c] = cm[c];
        return b;
    endfunction

    function automatic logic scanning(input kp_mode_e m);
        return (m == MODE_AUTO) || (m == MODE_HOST);
    endfunction
endpackage

// File: rtl/kp_row_sync.sv
module kp_row_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/kp_tick_gen.sv
module kp_tick_gen #(
    parameter int CLKS_PER_TICK = 100
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = $clog2(CLKS_PER_TICK + 1);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_TICK - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/kp_scan_engine.sv
module kp_scan_engine
    import kp_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  kp_cfg_t         cfg,
    input  logic            host_start,
    input  logic            armed,
    input  logic [COLS-1:0] colmask,
    input  logic [ROWS-1:0] rows_s,
    output logic [COLS-1:0] col_drv,
    output logic            press_evt,
    output logic            done,
    output logic [KEYS-1:0] result
);
    localparam int GUARD = SYNC_STAGES + 1;
    localparam int GW    = $clog2(GUARD + 1);
    localparam int CNT_W = $clog2(120 * TICKS_PER_MS + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [GW-1:0] GLAST = GW'(GUARD - 1);

    kp_state_e         state;
    logic [1:0]        col;
    logic              phase;
    logic [GW-1:0]     gcnt;
    logic [KEYS-1:0]   snap, prev;
    logic              first;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  period_t;

    assign period_t = CNT_W'(dbc_ms(cfg.dbc) * TICKS_PER_MS);

    always_comb begin
        case (state)
            ST_DETECT, ST_HOLD: col_drv = ~colmask;
            ST_COL:             col_drv = colmask[col] ? '0 : (COLS'(1) << col);
            default:            col_drv = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            col       <= '0;
            phase     <= 1'b0;
            gcnt      <= '0;
            snap      <= '0;
            prev      <= '0;
            first     <= 1'b1;
            cnt       <= '0;
            press_evt <= 1'b0;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            press_evt <= 1'b0;
            done      <= 1'b0;
            if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;

            if (!scanning(cfg.mode)) begin
                state <= ST_OFF;
            end else begin
                case (state)
                    ST_OFF: state <= ST_DETECT;
                    ST_DETECT, ST_HOLD: begin
                        if (cfg.mode == MODE_HOST && host_start) begin
                            state <= ST_COL; col <= '0; phase <= 1'b0;
                            snap <= '0; first <= 1'b1; cnt <= '0;
                        end else if (state == ST_DETECT && armed && (|rows_s)) begin
                            press_evt <= 1'b1;
                            if (cfg.mode == MODE_AUTO) begin
                                state <= ST_COL; col <= '0; phase <= 1'b0;
                                snap <= '0; first <= 1'b1; cnt <= '0;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_COL: begin
                        if (colmask[col] || (phase && gcnt == GLAST)) begin
                            if (!colmask[col])
                                for (int r = 0; r < ROWS; r++)
                                    snap[r*COLS + int'(col)] <= rows_s[r];
                            phase <= 1'b0;
                            if (col == 2'(COLS - 1)) state <= ST_EVAL;
                            else                     col <= col + 1'b1;
                        end else if (!phase) begin
                            if (tick) begin phase <= 1'b1; gcnt <= '0; end
                        end else begin
                            gcnt <= gcnt + 1'b1;
                        end
                    end
                    ST_EVAL: begin
                        state <= ST_COL; col <= '0; phase <= 1'b0; snap <= '0;
                        if (first || snap != prev) begin
                            prev  <= snap;
                            first <= 1'b0;
                            cnt   <= '0;
                        end else if (cnt >= period_t) begin
                            done   <= 1'b1;
                            result <= snap;
                            state  <= ST_DETECT;
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // R6: a masked column is never driven
    a_r6_masked_col_quiet: assert property (@(posedge clk) disable iff (rst)
        (col_drv & colmask) == '0);

    // R3: at most one column is strobed while the matrix is being sampled
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COL) |-> $onehot0(col_drv));

    // R4: a completed scan never follows a pass that saw a change
    a_r4_stable_before_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !first);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kp_pkg::*;
#(
    parameter int CLKS_PER_TICK = 100,
    parameter int TICKS_PER_MS  = 1000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic [3:0]  row_in,
    output logic [3:0]  col_drv,
    output logic        keyirq_n
);
    kp_cfg_t         cfg;
    logic [KEYS-1:0] kmask;
    logic [COLS-1:0] cmask;
    logic [KEYS-1:0] pending, status;
    logic            armed;
    logic            tick, press_evt, scan_done, host_start;
    logic [ROWS-1:0] rows_s;
    logic [KEYS-1:0] result;

    kp_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst(rst), .tick(tick));

    kp_row_sync #(.WIDTH(ROWS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(row_in), .q(rows_s));

    assign host_start = wr_en && addr == A_CFG && wdata[8];

    kp_scan_engine #(.SYNC_STAGES(SYNC_STAGES), .TICKS_PER_MS(TICKS_PER_MS)) u_eng (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg), .host_start(host_start),
        .armed(armed), .colmask(cmask), .rows_s(rows_s), .col_drv(col_drv),
        .press_evt(press_evt), .done(scan_done), .result(result));

    logic data_read;
    assign data_read = rd_en && (addr == A_PEND || addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            kmask    <= '0;
            cmask    <= '0;
            pending  <= '0;
            status   <= '0;
            armed    <= 1'b1;
            keyirq_n <= 1'b1;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CFG:   cfg   <= kp_cfg_t'(wdata[4:0]);
                    A_KMASK: kmask <= wdata;
                    A_CMASK: cmask <= wdata[COLS-1:0];
                    default: ;
                endcase
            end
            if (scan_done) begin
                pending <= result;
                status  <= result & ~kmask;
            end
            if (press_evt)      armed <= 1'b0;
            else if (data_read) armed <= 1'b1;
            if (press_evt)                               keyirq_n <= 1'b0;
            else if (scan_done || !scanning(cfg.mode))   keyirq_n <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            A_CFG:   rdata = {11'b0, cfg};
            A_KMASK: rdata = kmask;
            A_CMASK: rdata = {{(16-COLS){1'b0}}, cmask};
            A_PEND:  rdata = pending;
            A_STAT:  rdata = status;
            default: rdata = '0;
        endcase
    end

    // R7: the interrupt only falls while re-armed
    a_r7_fall_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $fell(keyirq_n) |-> $past(armed));

    // R7: the interrupt rises only on scan completion or when switched off
    a_r7_rise_on_done: assert property (@(posedge clk) disable iff (rst)
        $rose(keyirq_n) |-> ($past(scan_done) || !scanning($past(cfg.mode))));

    // R5: result words change only after a completed scan
    a_r5_pending_hold: assert property (@(posedge clk) disable iff (rst)
        !scan_done |=> $stable(pending));

    // R1: with the mode off, no column is driven
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !scanning(cfg.mode) |=> col_drv == '0);
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    localparam int CPT = 2;
    localparam int TPM = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  row_in, col_drv;
    logic        keyirq_n;
    logic [15:0] keys = '0;

    int checks = 0, errors = 0, cyc = 0;

    keypad_scanner #(.CLKS_PER_TICK(CPT), .TICKS_PER_MS(TPM), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .row_in(row_in), .col_drv(col_drv),
        .keyirq_n(keyirq_n));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // matrix model: row r high when a pressed key in a driven column sits on it
    always_comb
        for (int r = 0; r < 4; r++) row_in[r] = |(keys[r*4 +: 4] & col_drv);

    function automatic int period_clk(input int code);
        int ms [8] = '{2, 10, 20, 50, 60, 80, 100, 120};
        return ms[code] * TPM * CPT;
    endfunction

    function automatic logic [15:0] cbits(input logic [3:0] cm);
        logic [15:0] b = '0;
        for (int k = 0; k < 16; k++) b[k] = cm[k % 4];
        return b;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_irq(input logic lvl, input int lim, output logic ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (keyirq_n == lvl) begin ok = 1'b1; return; end
        end
    endtask

    // press keys, wait for a complete automatic scan, release, read results
    task automatic auto_scan(input logic [15:0] k, input logic [15:0] km,
                             input logic [3:0] cm, input string req);
        logic ok;
        logic [15:0] v, expp;
        expp = k & ~cbits(cm);
        keys = k;
        wait_irq(1'b0, 400, ok);
        chk(ok, {req, " R8 irq fall"}, keyirq_n, 0);
        wait_irq(1'b1, 3000, ok);
        chk(ok, {req, " R7 irq rise"}, keyirq_n, 1);
        keys = '0;
        repeat (20) @(negedge clk);
        rd(3'd3, v); chk(v == expp, {req, " R5 pending"}, v, expp);
        rd(3'd4, v); chk(v == (expp & ~km), {req, " R5 status"}, v, expp & ~km);
    endtask

    initial begin
        logic ok;
        logic [15:0] v;
        int t0, tlast, bad;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(keyirq_n == 1'b1, "R1 irq", keyirq_n, 1);
        chk(col_drv == 4'h0, "R1 col_drv", col_drv, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk(v == 16'h0, "R1 reg", v, 0);
        end
        keys = 16'h0020;
        repeat (100) @(negedge clk);
        chk(keyirq_n == 1'b1, "R1 off ignores press", keyirq_n, 1);
        wr(3'd0, 16'h0003);
        repeat (100) @(negedge clk);
        chk(keyirq_n == 1'b1 && col_drv == 0, "R1 mode 11 ignores press", keyirq_n, 1);
        keys = '0;

        // R11 / R2 / R4: auto mode with code 1
        wr(3'd0, 16'h0006);
        rd(3'd0, v); chk(v == 16'h0006, "R11 cfg readback", v, 6);
        repeat (5) @(negedge clk);
        chk(col_drv == 4'hF, "R2 detect drive", col_drv, 4'hF);
        keys = 16'h0020;
        wait_irq(1'b0, 400, ok); t0 = cyc;
        chk(ok, "R8 auto press irq", keyirq_n, 0);
        wait_irq(1'b1, 3000, ok);
        chk(ok && (cyc - t0) >= period_clk(1) && (cyc - t0) <= period_clk(1) + 120,
            "R4 period code 1", cyc - t0, period_clk(1));
        repeat (300) @(negedge clk);
        chk(keyirq_n == 1'b1, "R7 no refall before read", keyirq_n, 1);
        rd(3'd3, v); chk(v == 16'h0020, "R3 bit row1 col1", v, 16'h0020);
        wait_irq(1'b0, 100, ok);
        chk(ok, "R7 rearm after read", keyirq_n, 0);
        wait_irq(1'b1, 3000, ok);
        keys = '0; repeat (20) @(negedge clk);
        rd(3'd4, v);

        // R4 bounce restarts the window
        keys = 16'h0001;
        wait_irq(1'b0, 400, ok);
        repeat (30) @(negedge clk); keys = 16'h0003;
        repeat (30) @(negedge clk); keys = 16'h0001; tlast = cyc;
        wait_irq(1'b1, 3000, ok);
        chk(ok && (cyc - tlast) >= period_clk(1), "R4 bounce window", cyc - tlast, period_clk(1));
        keys = '0; repeat (20) @(negedge clk);
        rd(3'd3, v); chk(v == 16'h0001, "R4 settled value", v, 1);

        // R5 key mask
        wr(3'd0, 16'h0002);
        wr(3'd1, 16'h00F0);
        auto_scan(16'h0131, 16'h00F0, 4'h0, "R5 keymask");

        // R10 writes to result words ignored
        wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF);
        rd(3'd3, v); chk(v == 16'h0131, "R10 pending write", v, 16'h0131);
        rd(3'd4, v); chk(v == 16'h0101, "R10 status write", v, 16'h0101);

        // R6 column mask
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0004);
        keys = 16'h0040;
        repeat (200) @(negedge clk);
        chk(keyirq_n == 1'b1, "R6 masked column no irq", keyirq_n, 1);
        chk(col_drv == 4'hB, "R6 masked column drive", col_drv, 4'hB);
        auto_scan(16'h0041, 16'h0000, 4'h4, "R6 colmask");
        wr(3'd2, 16'h0000);

        // R9 host mode
        wr(3'd0, 16'h0001);
        keys = 16'h8000;
        wait_irq(1'b0, 400, ok);
        chk(ok, "R9 host irq", keyirq_n, 0);
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); if (col_drv != 4'hF) bad++;
        end
        chk(bad == 0 && keyirq_n == 0, "R9 no scan without start", bad, 0);
        wr(3'd0, 16'h0101);
        wait_irq(1'b1, 3000, ok);
        chk(ok, "R9 start completes", keyirq_n, 1);
        keys = '0; repeat (20) @(negedge clk);
        rd(3'd3, v); chk(v == 16'h8000, "R9 pending", v, 16'h8000);
        rd(3'd0, v); chk(v == 16'h0001, "R11 start reads 0", v, 1);

        // random patterns, auto mode code 0
        wr(3'd0, 16'h0002);
        for (int it = 0; it < 16; it++) begin
            logic [15:0] k, km;
            logic [3:0] cm;
            k  = 16'($urandom);
            km = 16'($urandom);
            cm = 4'($urandom) & 4'h7;
            if ((k & ~cbits(cm)) == 0) k = k | 16'h0008;
            wr(3'd1, km); wr(3'd2, {12'b0, cm});
            repeat (5) @(negedge clk);
            auto_scan(k, km, cm, "R3 random");
        end
        wr(3'd2, 16'h0);

        // R1 switching off
        wr(3'd0, 16'h0000);
        repeat (3) @(negedge clk);
        chk(col_drv == 4'h0 && keyirq_n == 1'b1, "R1 off again", col_drv, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule